// File: doc/BRIEF.md
# Edge Event Counter with Sticky Overflow

This block counts rising edges on one already-debounced input line in a 16-bit register. Software can read the count at any time and can write a new value into it at any time, so a count of N edges before overflow is set up by loading the maximum value minus N plus one. When the counter steps past its all-ones value it returns to zero and latches an overflow flag. The flag stays set until a dedicated overflow-clear pulse or a master-clear pulse arrives. Writing the counter does not touch it.

The flag drives an interrupt request through an enable bit. A typical use is to preload 0xFFFE, enable the interrupt, and take the request on the second rising edge. Three small state machines make up the block. An edge tracker (states EDGE_SYNC, EDGE_LOW, EDGE_HIGH) turns the level into a one-cycle step request. A counter sequencer picks one of CNT_HOLD, CNT_LOAD, CNT_STEP or CNT_WRAP each cycle. An overflow latch moves between OVF_IDLE and OVF_LATCHED.

Edge tracker transitions:
- EDGE_SYNC always leaves after one cycle, to EDGE_LOW or EDGE_HIGH depending on the level, and makes no step request.
- EDGE_LOW goes to EDGE_HIGH when the level is 1, and makes a step request on that transition.
- EDGE_HIGH goes back to EDGE_LOW when the level is 0.

Overflow latch transitions:
- OVF_IDLE goes to OVF_LATCHED on a wrap.
- OVF_LATCHED goes back to OVF_IDLE on a clear pulse when no wrap happens in the same cycle.

Top module: `evc_event_counter`

## Requirements
- R1: While reset is asserted and right after it, the count is 0x0000, the overflow status is 0 and the interrupt request is 0.
- R2: Each 0-to-1 transition of the input level raises the count by one on the next clock edge. A held high level and a 1-to-0 transition leave the count unchanged.
- R3: A level that is already high when reset is released is not counted. Only a later 0-to-1 transition counts.
- R4: A load request writes the load value into the count on the next clock edge. If a load and a rising edge arrive in the same cycle, the loaded value wins and the edge is lost.
- R5: A rising edge while the count is 0xFFFF takes the count to 0x0000 and sets the overflow status on that same clock edge.
- R6: Loading the counter leaves the overflow status unchanged.
- R7: The overflow-clear pulse or the master-clear pulse drops the overflow status on the next clock edge. Master clear leaves the count unchanged.
- R8: If an overflow and a clear pulse arrive in the same cycle, the overflow status ends up set.
- R9: The interrupt request is 1 exactly when the overflow status is 1 and the interrupt enable input is 1.
- R10: After a preload of 0xFFFE with the interrupt enabled, the first rising edge raises no request and the second raises one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_level | input | 1 | Debounced input level whose rising edges are counted |
| load_en | input | 1 | Host write strobe for the count |
| load_value | input | 16 | Value written into the count on a load |
| count_out | output | 16 | Current count |
| ovf_clr | input | 1 | One-cycle pulse that clears the overflow status |
| master_clr | input | 1 | One-cycle pulse that clears the overflow status (block-wide clear) |
| ovf_irq_en | input | 1 | Interrupt enable for the overflow status |
| ovf_status | output | 1 | Sticky overflow status |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The bench uses the default counter width of 16 bits, so every value it checks is the one software would see. Stepping through 65536 edges would take too long, so the bench reaches the wrap boundary by preloading 0xFFFE and 0xFFFF. This also covers the two-edge interrupt case and the case where a wrap meets a clear. A separate reset with the level held high exercises the EDGE_SYNC path, which an ordinary run never reaches.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [1:0] {
        EDGE_SYNC = 2'd0,
        EDGE_LOW  = 2'd1,
        EDGE_HIGH = 2'd2
    } edge_state_e;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_STEP = 2'd2,
        CNT_WRAP = 2'd3
    } cnt_op_e;

    typedef enum logic {
        OVF_IDLE    = 1'b0,
        OVF_LATCHED = 1'b1
    } ovf_state_e;

endpackage

// File: rtl/evc_edge_fsm.sv
module evc_edge_fsm
    import evc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    edge_state_e state_q;
    edge_state_e state_d;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_SYNC: state_d = level ? EDGE_HIGH : EDGE_LOW;
            EDGE_LOW:  if (level)  state_d = EDGE_HIGH;
            EDGE_HIGH: if (!level) state_d = EDGE_LOW;
            default:   state_d = EDGE_SYNC;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDGE_SYNC;
        else        state_q <= state_d;
    end

    // output process: step request only on a seen low-to-high move
    always_comb begin
        rise = 1'b0;
        unique case (state_q)
            EDGE_SYNC: rise = 1'b0;
            EDGE_LOW:  rise = level;
            EDGE_HIGH: rise = 1'b0;
            default:   rise = 1'b0;
        endcase
    end

endmodule

// File: rtl/evc_count_core.sv
module evc_count_core
    import evc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_value,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_op_e          op;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;

    // operation select: load beats step, wrap is a step at the top value
    always_comb begin
        if (load_en)                      op = CNT_LOAD;
        else if (step && count_q == CNT_MAX) op = CNT_WRAP;
        else if (step)                    op = CNT_STEP;
        else                              op = CNT_HOLD;
    end

    always_comb begin
        count_d = count_q;
        unique case (op)
            CNT_HOLD: count_d = count_q;
            CNT_LOAD: count_d = load_value;
            CNT_STEP: count_d = count_q + CNT_ONE;
            CNT_WRAP: count_d = CNT_ZERO;
            default:  count_d = count_q;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= CNT_ZERO;
        else        count_q <= count_d;
    end

    // outputs
    always_comb begin
        count = count_q;
        wrap  = (op == CNT_WRAP);
    end

endmodule

// File: rtl/evc_ovf_latch.sv
module evc_ovf_latch
    import evc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic clr,
    input  logic mclr,
    input  logic irq_en,
    output logic status,
    output logic irq
);

    ovf_state_e state_q;
    ovf_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVF_IDLE:    if (wrap) state_d = OVF_LATCHED;
            OVF_LATCHED: if ((clr || mclr) && !wrap) state_d = OVF_IDLE;
            default:     state_d = OVF_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OVF_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        status = 1'b0;
        unique case (state_q)
            OVF_IDLE:    status = 1'b0;
            OVF_LATCHED: status = 1'b1;
            default:     status = 1'b0;
        endcase
        irq = status & irq_en;
    end

endmodule

// File: rtl/evc_event_counter.sv
module evc_event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_level,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_value,
    output logic [CNT_W-1:0] count_out,
    input  logic             ovf_clr,
    input  logic             master_clr,
    input  logic             ovf_irq_en,
    output logic             ovf_status,
    output logic             ovf_irq
);

    logic rise_pulse;
    logic wrap_pulse;

    evc_edge_fsm u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (evt_level),
        .rise  (rise_pulse)
    );

    evc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_value (load_value),
        .step       (rise_pulse),
        .count      (count_out),
        .wrap       (wrap_pulse)
    );

    evc_ovf_latch u_ovf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap   (wrap_pulse),
        .clr    (ovf_clr),
        .mclr   (master_clr),
        .irq_en (ovf_irq_en),
        .status (ovf_status),
        .irq    (ovf_irq)
    );

endmodule

// File: rtl/evc_event_counter_chk.sv
module evc_event_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_en,
    input logic [CNT_W-1:0] load_value,
    input logic [CNT_W-1:0] count_out,
    input logic             ovf_clr,
    input logic             master_clr,
    input logic             ovf_irq_en,
    input logic             ovf_status,
    input logic             ovf_irq,
    input logic             wrap_pulse
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R4
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_en) |-> count_out == $past(load_value));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_en) && count_out != $past(count_out) && $past(count_out) != TOP)
            |-> count_out == $past(count_out) + ONE);

    // R5
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_en) && $past(count_out) == TOP && count_out == '0) |-> ovf_status);

    // R6
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_status) && !$past(ovf_clr) && !$past(master_clr)) |-> ovf_status);

    // R7
    clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ovf_clr) || $past(master_clr)) && !$past(wrap_pulse)) |-> !ovf_status);

    // R8
    wrap_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wrap_pulse) |-> ovf_status);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> (ovf_status && ovf_irq_en));

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_irq_en |-> !ovf_irq);

endmodule

bind evc_event_counter evc_event_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .load_value (load_value),
    .count_out  (count_out),
    .ovf_clr    (ovf_clr),
    .master_clr (master_clr),
    .ovf_irq_en (ovf_irq_en),
    .ovf_status (ovf_status),
    .ovf_irq    (ovf_irq),
    .wrap_pulse (wrap_pulse)
);

// File: tb/evc_event_counter_bench.sv
`timescale 1ns/1ps
module evc_event_counter_bench;

    localparam int W = 16;

    // {lvl, ld, val, clr, mclr, en, exp_cnt, exp_st, exp_irq}
    typedef struct packed {
        logic         lvl;
        logic         ld;
        logic [W-1:0] val;
        logic         clr;
        logic         mclr;
        logic         en;
        logic [W-1:0] ecnt;
        logic         est;
        logic         eirq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0}, // R1 idle
        '{1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b0}, // R2 edge
        '{1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b0}, // R2 held
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b0}, // R2 fall
        '{1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0002, 1'b0, 1'b0}, // R2 edge
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0002, 1'b0, 1'b0}, // R2
        '{1'b0, 1'b1, 16'hFFFE, 1'b0, 1'b0, 1'b1, 16'hFFFE, 1'b0, 1'b0}, // R4 load
        '{1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0}, // R10 1st edge
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0}, // R10
        '{1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b1}, // R5 R10 2nd edge
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0}, // R9 masked
        '{1'b0, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b1, 16'h1234, 1'b1, 1'b1}, // R6 load keeps
        '{1'b1, 1'b1, 16'h0050, 1'b0, 1'b0, 1'b1, 16'h0050, 1'b1, 1'b1}, // R4 load beats edge
        '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h0050, 1'b0, 1'b0}, // R7 clear
        '{1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0}, // R4
        '{1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h0000, 1'b1, 1'b1}, // R8 wrap beats clear
        '{1'b0, 1'b1, 16'h0007, 1'b0, 1'b0, 1'b1, 16'h0007, 1'b1, 1'b1}, // R6
        '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h0007, 1'b0, 1'b0}  // R7 master
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         evt_level = 1'b0;
    logic         load_en = 1'b0;
    logic [W-1:0] load_value = '0;
    logic [W-1:0] count_out;
    logic         ovf_clr = 1'b0;
    logic         master_clr = 1'b0;
    logic         ovf_irq_en = 1'b0;
    logic         ovf_status;
    logic         ovf_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    evc_event_counter #(.CNT_W(W)) u_evc_event_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_level  (evt_level),
        .load_en    (load_en),
        .load_value (load_value),
        .count_out  (count_out),
        .ovf_clr    (ovf_clr),
        .master_clr (master_clr),
        .ovf_irq_en (ovf_irq_en),
        .ovf_status (ovf_status),
        .ovf_irq    (ovf_irq)
    );

    task automatic check(input string req, input logic [W-1:0] ecnt,
                         input logic est, input logic eirq);
        n_checks++;
        if (count_out !== ecnt || ovf_status !== est || ovf_irq !== eirq) begin
            n_fails++;
            $display("FAIL %s: got cnt=%h st=%b irq=%b, expected cnt=%h st=%b irq=%b",
                     req, count_out, ovf_status, ovf_irq, ecnt, est, eirq);
        end
    endtask

    task automatic idle_inputs();
        load_en = 1'b0; ovf_clr = 1'b0; master_clr = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 16'h0000, 1'b0, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            evt_level  = VECS[i].lvl;
            load_en    = VECS[i].ld;
            load_value = VECS[i].val;
            ovf_clr    = VECS[i].clr;
            master_clr = VECS[i].mclr;
            ovf_irq_en = VECS[i].en;
            tick();
            check($sformatf("vector %0d (R1..R10 per table)", i),
                  VECS[i].ecnt, VECS[i].est, VECS[i].eirq);
        end
        idle_inputs();

        // R1: reset in the middle of activity, flag set beforehand
        ovf_irq_en = 1'b1;
        load_en = 1'b1; load_value = 16'hFFFF; tick();
        load_en = 1'b0; evt_level = 1'b1; tick();
        check("R5 setup", 16'h0000, 1'b1, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", 16'h0000, 1'b0, 1'b0);

        // R3: level already high at reset release
        evt_level = 1'b1;
        tick();
        rst_n = 1'b1;
        tick(); tick(); tick();
        check("R3 high at release", 16'h0000, 1'b0, 1'b0);
        evt_level = 1'b0; tick();
        evt_level = 1'b1; tick();
        check("R3 later edge", 16'h0001, 1'b0, 1'b0);

        // R9: enable toggling alone
        evt_level = 1'b0;
        load_en = 1'b1; load_value = 16'hFFFF; tick();
        load_en = 1'b0; ovf_irq_en = 1'b0; evt_level = 1'b1; tick();
        check("R9 disabled", 16'h0000, 1'b1, 1'b0);
        ovf_irq_en = 1'b1; #1;
        check("R9 enabled", 16'h0000, 1'b1, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule